// File: doc/BRIEF.md
# Load/Store Byte Lane Aligner

This block sits between the load/store stage of a 32-bit processor and a data memory that is one word wide. For every access it adds a base register value to a sign-extended 16-bit displacement to form the effective address. A store moves the byte, halfword or word from the source register onto the byte lanes that the address selects and raises the matching byte enables. A load takes the word the memory returns, picks out the addressed byte or halfword and widens it to 32 bits with sign or zero extension.

Only naturally aligned accesses go to memory. A halfword at an odd address, a word whose address is not a multiple of four, or the unused size code raises a one-cycle address error and produces no memory request, so a faulting store writes nothing. By default the most significant byte sits at the lowest address (big-endian). A parameter selects the reverse mapping instead.

The request is registered once, so the memory request appears on the cycle after the request. The memory returns read data one or more cycles after a read request, with a valid strobe. Only one read is outstanding at a time. The widened load result is registered one cycle after that strobe.

Top module: `lsa_top`

## Requirements
- R1: One cycle after `req_valid`, `mem_addr` equals `req_base` plus `req_disp` sign-extended to 32 bits, modulo 2^32.
- R2: A zero displacement yields the base value as the address, and a zero base yields the sign-extended displacement alone.
- R3: The size code is 0 for byte, 1 for halfword, 2 for word. `mem_be` has one bit set for a byte, two adjacent bits for a halfword and all four bits for a word.
- R4: Lane j is `mem_wdata`/`mem_rdata` bits 8j+7:8j. With `BIG_ENDIAN`=1, the byte at address offset k (address bits 1:0) uses lane 3-k. With `BIG_ENDIAN`=0, it uses lane k.
- R5: A store puts the low 8 bits (byte) or low 16 bits (halfword, most significant byte at the lower address in big-endian mode) or all 32 bits of `req_wdata` on the enabled lanes. It drives zero on the other lanes and asserts `mem_write`.
- R6: A byte or halfword load with `req_zext`=0 sign-extends the picked field, and with `req_zext`=1 it zero-extends it. A word load returns the memory word unchanged.
- R7: A halfword at an odd address or a word at an address not divisible by 4 sets `addr_err` for exactly one cycle in place of `mem_valid`. No memory request is made, and no load result follows.
- R8: During reset `mem_valid`, `addr_err` and `load_valid` are low. Without a request, `mem_valid` and `addr_err` stay low.
- R9: Size code 3 is reserved and is handled like a misaligned access: `addr_err` is set and no request is made.
- R10: `load_valid` rises exactly one cycle after `mem_rvalid` and carries the widened result in `load_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_zext | input | 1 | Load widening: 1 zero-extend, 0 sign-extend |
| req_base | input | 32 | Base register value |
| req_disp | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store source register value |
| mem_valid | output | 1 | Memory request strobe |
| mem_write | output | 1 | Request is a write |
| mem_addr | output | 32 | Effective byte address |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Lane-positioned store data |
| addr_err | output | 1 | Misaligned or reserved-size access |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Returned memory word |
| load_valid | output | 1 | Load result strobe |
| load_data | output | 32 | Widened load result |

## Verification
The bench builds two copies side by side on the same stimulus: one with `BIG_ENDIAN`=1 and one with `BIG_ENDIAN`=0. Every lane placement and extraction is therefore checked under both mappings at once. It sweeps every size code, every offset inside the word, both store and load, and both extension kinds. It uses bases and displacements that reach zero, wrap past 2^32 and hit the most negative and most positive displacements. Every alignment case and the address arithmetic at its limits are therefore covered.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } lsa_size_e;
endpackage

// File: rtl/lsa_addr_gen.sv
module lsa_addr_gen
  import lsa_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  parameter int LW     = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [DISP_W-1:0] disp,
  input  lsa_size_e         size,
  output logic [ADDR_W-1:0] ea,
  output logic              bad
);
  localparam int EXT_W = ADDR_W - DISP_W;

  assign ea = base + {{EXT_W{disp[DISP_W-1]}}, disp};

  // natural alignment rule per access size
  always_comb begin
    unique case (size)
      SZ_BYTE: bad = 1'b0;
      SZ_HALF: bad = ea[0];
      SZ_WORD: bad = |ea[LW-1:0];
      default: bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/lsa_lane_sel.sv
module lsa_lane_sel
  import lsa_pkg::*;
#(
  parameter int BYTES      = 4,
  parameter bit BIG_ENDIAN = 1'b1,
  parameter int LW         = 2
) (
  input  logic [LW-1:0]    off,
  input  lsa_size_e        size,
  output logic [LW-1:0]    lane_lo,
  output logic [BYTES-1:0] be
);
  logic [BYTES-1:0] mask;

  always_comb begin
    unique case (size)
      SZ_BYTE: mask = BYTES'(1);
      SZ_HALF: mask = BYTES'(3);
      SZ_WORD: mask = '1;
      default: mask = '0;
    endcase
  end

  generate
    if (BIG_ENDIAN) begin : g_big
      always_comb begin
        unique case (size)
          SZ_BYTE: lane_lo = LW'(BYTES - 1) - off;
          SZ_HALF: lane_lo = LW'(BYTES - 2) - off;
          default: lane_lo = '0;
        endcase
      end
    end else begin : g_little
      always_comb begin
        unique case (size)
          SZ_BYTE, SZ_HALF: lane_lo = off;
          default:          lane_lo = '0;
        endcase
      end
    end
  endgenerate

  assign be = mask << lane_lo;
endmodule

// File: rtl/lsa_store_pack.sv
module lsa_store_pack
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LW     = 2
) (
  input  logic [DATA_W-1:0] src,
  input  lsa_size_e         size,
  input  logic [LW-1:0]     lane_lo,
  output logic [DATA_W-1:0] wdata
);
  logic [DATA_W-1:0] trimmed;

  always_comb begin
    unique case (size)
      SZ_BYTE: trimmed = DATA_W'(src[7:0]);
      SZ_HALF: trimmed = DATA_W'(src[15:0]);
      default: trimmed = src;
    endcase
  end

  assign wdata = trimmed << {lane_lo, 3'b000};
endmodule

// File: rtl/lsa_load_unpack.sv
module lsa_load_unpack
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LW     = 2
) (
  input  logic [DATA_W-1:0] rdata,
  input  lsa_size_e         size,
  input  logic              zext,
  input  logic [LW-1:0]     lane_lo,
  output logic [DATA_W-1:0] value
);
  logic [DATA_W-1:0] shifted;
  logic              fill;

  assign shifted = rdata >> {lane_lo, 3'b000};

  always_comb begin
    fill = 1'b0;
    unique case (size)
      SZ_BYTE: begin
        fill  = ~zext & shifted[7];
        value = {{(DATA_W-8){fill}}, shifted[7:0]};
      end
      SZ_HALF: begin
        fill  = ~zext & shifted[15];
        value = {{(DATA_W-16){fill}}, shifted[15:0]};
      end
      default: value = rdata;
    endcase
  end
endmodule

// File: rtl/lsa_top.sv
module lsa_top
  import lsa_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int DISP_W     = 16,
  parameter bit BIG_ENDIAN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [1:0]        req_size,
  input  logic              req_zext,
  input  logic [DATA_W-1:0] req_base,
  input  logic [DISP_W-1:0] req_disp,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W/8-1:0] mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              addr_err,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              load_valid,
  output logic [DATA_W-1:0] load_data
);
  localparam int BYTES = DATA_W / 8;
  localparam int LW    = $clog2(BYTES);

  lsa_size_e         size_in;
  logic [DATA_W-1:0] ea;
  logic              bad;
  logic [LW-1:0]     lane_lo;
  logic [BYTES-1:0]  be_d;
  logic [DATA_W-1:0] wdata_d;
  logic [DATA_W-1:0] ld_value;

  // load context captured with each issued read
  lsa_size_e         ctx_size_q, ctx_size_d;
  logic              ctx_zext_q, ctx_zext_d;
  logic [LW-1:0]     ctx_lane_q, ctx_lane_d;

  // registered request outputs and their next values
  logic              valid_d, write_d, err_d;
  logic              ld_valid_d;
  logic [DATA_W-1:0] addr_d, mem_wdata_d, ld_data_d;
  logic [BYTES-1:0]  mem_be_d;
  logic              req_en, ctx_en, ld_en;

  assign size_in = lsa_size_e'(req_size);

  lsa_addr_gen #(.ADDR_W(DATA_W), .DISP_W(DISP_W), .LW(LW)) u_addr (
    .base (req_base),
    .disp (req_disp),
    .size (size_in),
    .ea   (ea),
    .bad  (bad)
  );

  lsa_lane_sel #(.BYTES(BYTES), .BIG_ENDIAN(BIG_ENDIAN), .LW(LW)) u_lane (
    .off     (ea[LW-1:0]),
    .size    (size_in),
    .lane_lo (lane_lo),
    .be      (be_d)
  );

  lsa_store_pack #(.DATA_W(DATA_W), .LW(LW)) u_pack (
    .src     (req_wdata),
    .size    (size_in),
    .lane_lo (lane_lo),
    .wdata   (wdata_d)
  );

  lsa_load_unpack #(.DATA_W(DATA_W), .LW(LW)) u_unpack (
    .rdata   (mem_rdata),
    .size    (ctx_size_q),
    .zext    (ctx_zext_q),
    .lane_lo (ctx_lane_q),
    .value   (ld_value)
  );

  // next-state logic
  always_comb begin
    req_en      = req_valid;
    ctx_en      = req_valid & ~req_store & ~bad;
    ld_en       = mem_rvalid;
    valid_d     = req_valid & ~bad;
    err_d       = req_valid & bad;
    ld_valid_d  = mem_rvalid;
    write_d     = req_store;
    addr_d      = ea;
    mem_be_d    = be_d;
    mem_wdata_d = req_store ? wdata_d : '0;
    ctx_size_d  = size_in;
    ctx_zext_d  = req_zext;
    ctx_lane_d  = lane_lo;
    ld_data_d   = ld_value;
  end

  // strobes: reset to idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_valid  <= 1'b0;
      addr_err   <= 1'b0;
      load_valid <= 1'b0;
    end else begin
      mem_valid  <= valid_d;
      addr_err   <= err_d;
      load_valid <= ld_valid_d;
    end
  end

  // datapath registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_write  <= 1'b0;
      mem_addr   <= '0;
      mem_be     <= '0;
      mem_wdata  <= '0;
      ctx_size_q <= SZ_WORD;
      ctx_zext_q <= 1'b0;
      ctx_lane_q <= '0;
      load_data  <= '0;
    end else begin
      if (req_en) begin
        mem_write <= write_d;
        mem_addr  <= addr_d;
        mem_be    <= mem_be_d;
        mem_wdata <= mem_wdata_d;
      end
      if (ctx_en) begin
        ctx_size_q <= ctx_size_d;
        ctx_zext_q <= ctx_zext_d;
        ctx_lane_q <= ctx_lane_d;
      end
      if (ld_en) begin
        load_data <= ld_data_d;
      end
    end
  end
endmodule

// File: rtl/lsa_top_chk.sv
module lsa_top_chk #(
  parameter int DATA_W = 32,
  parameter int DISP_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic [1:0]          req_size,
  input logic [DATA_W-1:0]   req_base,
  input logic [DISP_W-1:0]   req_disp,
  input logic                mem_valid,
  input logic                mem_write,
  input logic [DATA_W-1:0]   mem_addr,
  input logic [DATA_W/8-1:0] mem_be,
  input logic [DATA_W-1:0]   mem_wdata,
  input logic                addr_err,
  input logic                mem_rvalid,
  input logic                load_valid
);
  localparam int BYTES = DATA_W / 8;

  logic [DATA_W-1:0] lane_bits;
  always_comb begin
    for (int j = 0; j < BYTES; j++) lane_bits[8*j +: 8] = {8{mem_be[j]}};
  end

  // R1
  ea_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> mem_addr == $past(req_base) +
                  {{(DATA_W-DISP_W){$past(req_disp[DISP_W-1])}}, $past(req_disp)});

  // R3
  be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 ||
                   $countones(mem_be) == BYTES));

  // R5
  idle_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write) |-> (mem_wdata & ~lane_bits) == '0);

  // R7
  err_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> !mem_valid);

  // R8
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!mem_valid && !addr_err));

  // R9
  rsvd_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == 2'd3) |=> (addr_err && !mem_valid));

  // R10
  load_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rvalid |=> load_valid);

  // R10
  load_no_spur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rvalid |=> !load_valid);
endmodule

bind lsa_top lsa_top_chk #(.DATA_W(DATA_W), .DISP_W(DISP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_size   (req_size),
  .req_base   (req_base),
  .req_disp   (req_disp),
  .mem_valid  (mem_valid),
  .mem_write  (mem_write),
  .mem_addr   (mem_addr),
  .mem_be     (mem_be),
  .mem_wdata  (mem_wdata),
  .addr_err   (addr_err),
  .mem_rvalid (mem_rvalid),
  .load_valid (load_valid)
);

// File: tb/tb_lsa_top.sv
module tb_lsa_top;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        req_valid, req_store, req_zext;
  logic [1:0]  req_size;
  logic [31:0] req_base, req_wdata;
  logic [15:0] req_disp;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;

  logic        b_valid, b_write, b_err, b_lvalid;
  logic [31:0] b_addr, b_wdata, b_ldata;
  logic [3:0]  b_be;
  logic        l_valid, l_write, l_err, l_lvalid;
  logic [31:0] l_addr, l_wdata, l_ldata;
  logic [3:0]  l_be;

  int checks = 0;
  int errors = 0;

  lsa_top #(.BIG_ENDIAN(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_zext(req_zext), .req_base(req_base),
    .req_disp(req_disp), .req_wdata(req_wdata),
    .mem_valid(b_valid), .mem_write(b_write), .mem_addr(b_addr), .mem_be(b_be),
    .mem_wdata(b_wdata), .addr_err(b_err), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .load_valid(b_lvalid), .load_data(b_ldata)
  );

  lsa_top #(.BIG_ENDIAN(1'b0)) dut_le (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_zext(req_zext), .req_base(req_base),
    .req_disp(req_disp), .req_wdata(req_wdata),
    .mem_valid(l_valid), .mem_write(l_write), .mem_addr(l_addr), .mem_be(l_be),
    .mem_wdata(l_wdata), .addr_err(l_err), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .load_valid(l_lvalid), .load_data(l_ldata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_pat(input logic [31:0] a);
    return ({2'b00, a[31:2]} * 32'h9E3779B1) ^ 32'h8070F0A5;
  endfunction

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  // lane j holds memory byte offset (big ? 3-j : j)
  function automatic logic [3:0] exp_be(input logic [1:0] off, input int n, input bit big);
    logic [3:0] r;
    for (int j = 0; j < 4; j++) begin
      int pos;
      pos  = big ? 3 - j : j;
      r[j] = (pos >= off) && (pos < off + n);
    end
    return r;
  endfunction

  function automatic logic [31:0] exp_wd(input logic [1:0] off, input int n, input bit big,
                                         input logic [31:0] src);
    logic [31:0] r;
    r = '0;
    for (int j = 0; j < 4; j++) begin
      int pos, k, idx;
      pos = big ? 3 - j : j;
      if (pos >= off && pos < off + n) begin
        k   = pos - off;
        idx = big ? n - 1 - k : k;
        r[8*j +: 8] = src[8*idx +: 8];
      end
    end
    return r;
  endfunction

  function automatic logic [31:0] exp_ld(input logic [1:0] off, input int n, input bit big,
                                         input bit zx, input logic [31:0] rd);
    logic [31:0] v;
    v = '0;
    for (int j = 0; j < 4; j++) begin
      int pos, k, idx;
      pos = big ? 3 - j : j;
      if (pos >= off && pos < off + n) begin
        k   = pos - off;
        idx = big ? n - 1 - k : k;
        v[8*idx +: 8] = rd[8*j +: 8];
      end
    end
    if (n == 1 && !zx && v[7])  v[31:8]  = '1;
    if (n == 2 && !zx && v[15]) v[31:16] = '1;
    return v;
  endfunction

  task automatic access(input bit st, input logic [1:0] sz, input bit zx,
                        input logic [31:0] base, input logic [15:0] disp,
                        input logic [31:0] src);
    logic [31:0] ea;
    bit          bad;
    int          n;
    string       atag, etag;
    ea   = base + {{16{disp[15]}}, disp};
    n    = nbytes(sz);
    bad  = (sz == 2'd3) || (sz == 2'd1 && ea[0]) || (sz == 2'd2 && ea[1:0] != 2'b00);
    atag = (base == 0 || disp == 0) ? "R2 addr" : "R1 addr";
    etag = (sz == 2'd3) ? "R9 err" : "R7 err";
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_size = sz; req_zext = zx;
    req_base = base; req_disp = disp; req_wdata = src;
    @(negedge clk);
    req_valid = 1'b0;
    chk(atag, b_addr, ea);
    chk(atag, l_addr, ea);
    chk(etag, {31'd0, b_err}, {31'd0, bad});
    chk(etag, {31'd0, l_err}, {31'd0, bad});
    chk("R7 valid", {31'd0, b_valid}, {31'd0, !bad});
    chk("R7 valid", {31'd0, l_valid}, {31'd0, !bad});
    if (!bad) begin
      chk("R3 R4 be big", {28'd0, b_be}, {28'd0, exp_be(ea[1:0], n, 1'b1)});
      chk("R3 R4 be little", {28'd0, l_be}, {28'd0, exp_be(ea[1:0], n, 1'b0)});
      chk("R5 write", {31'd0, b_write}, {31'd0, st});
      if (st) begin
        chk("R5 wdata big", b_wdata, exp_wd(ea[1:0], n, 1'b1, src));
        chk("R5 wdata little", l_wdata, exp_wd(ea[1:0], n, 1'b0, src));
      end else begin
        mem_rvalid = 1'b1;
        mem_rdata  = rd_pat(ea);
        @(negedge clk);
        mem_rvalid = 1'b0;
        chk("R10 lvalid", {30'd0, b_lvalid, l_lvalid}, 32'd3);
        chk("R6 load big", b_ldata, exp_ld(ea[1:0], n, 1'b1, zx, rd_pat(ea)));
        chk("R6 load little", l_ldata, exp_ld(ea[1:0], n, 1'b0, zx, rd_pat(ea)));
      end
    end else begin
      @(negedge clk);
      chk("R7 no load", {30'd0, b_lvalid, l_lvalid}, 32'd0);
      chk("R7 idle", {30'd0, b_valid, l_valid}, 32'd0);
    end
  endtask

  initial begin
    logic [31:0] bases [4];
    logic [15:0] disps [8];
    bases = '{32'h0000_0000, 32'h0000_1000, 32'hFFFF_FFFC, 32'h7FFF_FFF0};
    disps = '{16'h0000, 16'h0001, 16'h0002, 16'h0003,
              16'hFFFF, 16'h8000, 16'h7FFF, 16'hFFFE};
    rst_n = 1'b0; req_valid = 1'b0; req_store = 1'b0; req_size = 2'd0;
    req_zext = 1'b0; req_base = '0; req_disp = '0; req_wdata = '0;
    mem_rvalid = 1'b0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    chk("R8 reset", {26'd0, b_valid, b_err, b_lvalid, l_valid, l_err, l_lvalid}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 idle", {28'd0, b_valid, b_err, l_valid, l_err}, 32'd0);

    // R2 corner: zero base, negative displacement
    access(1'b0, 2'd2, 1'b0, 32'h0, 16'hFFF8, 32'h0);
    // R6 fixed patterns with sign bit set and clear
    access(1'b0, 2'd0, 1'b0, 32'h40, 16'h0000, 32'h0);
    access(1'b0, 2'd1, 1'b1, 32'h40, 16'h0002, 32'h0);

    for (int bi = 0; bi < 4; bi++) begin
      for (int di = 0; di < 8; di++) begin
        for (int sz = 0; sz < 4; sz++) begin
          for (int st = 0; st < 2; st++) begin
            for (int zx = 0; zx < 2; zx++) begin
              access(st[0], sz[1:0], zx[0], bases[bi], disps[di],
                     rd_pat(bases[bi] + 32'(di * 7 + sz)) ^ 32'h5A5A_A5A5);
            end
          end
        end
      end
    end

    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule